// File: doc/BRIEF.md
# Serial Flash Protection-Bit Command Engine

This block models the slave-side logic of a serial NOR flash that manages a small array of persistent protection bits and an 8-bit lock register. The serial pins (SCK, chip select, serial in) are brought into the system clock domain and sampled there. Opcodes arrive most significant bit first. Each opcode is 8 bits, latched on rising SCK while chip select is low.

A host sets the write-enable latch and then issues an erase of the protection array. The erase runs as a timed internal busy cycle and is visible through the write-in-progress bit of the status byte. The host can stream out the status byte or the lock register. A lock-set command clears the lock register's bit 0 for test. The serial output is enabled only while a read is actually driving data.

Top module: `flprot_engine`

## Requirements
- R1: After reset the status byte is 00h, the lock register is 01h, the protection bits equal PROT_INIT and so_oe is 0.
- R2: Opcode 06h (write enable), sent as exactly eight bits before cs_n rises, sets the write-enable latch, which is status bit 1.
- R3: Opcode 05h streams the status byte on so_o, MSB first, with each bit updated after a falling SCK. Bit 0 is write-in-progress, bit 1 is the write-enable latch and bits 7..2 are 0. The byte repeats every eight further clocks while cs_n stays low.
- R4: Opcode A7h streams the lock register the same way, repeating every eight clocks, but only when no erase is running; otherwise so_oe stays 0 for the whole selection.
- R5: Opcode A6h, sent as exactly eight bits, clears bit 0 of the lock register, so that a following lock read returns 00h.
- R6: Opcode E4h with exactly eight bits and the write-enable latch set starts an erase. Write-in-progress reads 1 for ERASE_CYCLES system clocks. After that all 16 protection bits are 1, and write-in-progress and the write-enable latch both read 0.
- R7: Opcode E4h sent while the write-enable latch is clear starts nothing and leaves the protection bits unchanged.
- R8: Opcode E4h followed by more than eight bits before cs_n rises is discarded: the protection bits are unchanged and a set write-enable latch is cleared.
- R9: Opcode 75h (suspend) during an erase is ignored: write-in-progress stays 1 and the erase ends on schedule.
- R10: While an erase runs, opcodes 06h, E4h and A6h are ignored; in particular the lock register keeps its value.
- R11: so_oe is 0 whenever no status or lock read is active, including for unknown opcodes, and falls within one system clock after the synchronised cs_n goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial data out enable; 0 means high impedance |
| prot_bits | output | PROT_W | Current protection-bit array |

## Verification
Two functions overlap in time: the internal erase timer, and new serial commands that arrive while it counts. The bench starts an erase and, before the timer expires, sends a lock read, a suspend, a lock-set and a status read. It then judges four things. The lock read must never enable SO. The status byte must still show write-in-progress. The lock register must be untouched once the erase completes. The protection array must flip to all ones only at the end of the busy window, which a checker also measures in system clocks.

// File: rtl/flprot_pkg.sv
// Shared opcodes and command types for the protection-bit engine.
package flprot_pkg;
    localparam logic [7:0] OP_WREN    = 8'h06;
    localparam logic [7:0] OP_RDSR    = 8'h05;
    localparam logic [7:0] OP_ERASE   = 8'hE4;
    localparam logic [7:0] OP_RDLOCK  = 8'hA7;
    localparam logic [7:0] OP_LOCKSET = 8'hA6;
    localparam logic [7:0] OP_SUSPEND = 8'h75;

    typedef enum logic [1:0] {
        PEND_NONE  = 2'd0,
        PEND_WREN  = 2'd1,
        PEND_ERASE = 2'd2,
        PEND_LOCK  = 2'd3
    } pend_e;
endpackage

// File: rtl/flprot_spi_front.sv
// Serial front end. Synchronises sck, cs_n and si into clk and shifts opcode
// bits in on rising SCK, MSB first. Emits a one-cycle strobe on the eighth bit
// and on each chip-select release.
// Assumes SCK phases last several clk periods.
module flprot_spi_front #(
    parameter int OPW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sck,
    input  logic           cs_n,
    input  logic           si,
    output logic           cs_sync,
    output logic           fall_stb,
    output logic           op_stb,
    output logic [OPW-1:0] op_code,
    output logic           cs_end,
    output logic           exact_len
);
    localparam int CW = $clog2(OPW + 2) + 1;
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic sck_m, sck_s, sck_d;
    logic cs_m, cs_s, cs_d;
    logic si_m, si_s;
    logic rise_stb;
    logic [CW-1:0]  bit_cnt;
    logic [OPW-1:0] shreg;

    // Two-stage synchronisers plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_m <= 1'b0; sck_s <= 1'b0; sck_d <= 1'b0;
            cs_m  <= 1'b1; cs_s  <= 1'b1; cs_d  <= 1'b1;
            si_m  <= 1'b0; si_s  <= 1'b0;
        end else begin
            sck_m <= sck;  sck_s <= sck_m;  sck_d <= sck_s;
            cs_m  <= cs_n; cs_s  <= cs_m;   cs_d  <= cs_s;
            si_m  <= si;   si_s  <= si_m;
        end
    end

    assign rise_stb = sck_s & ~sck_d & ~cs_s;
    assign fall_stb = ~sck_s & sck_d & ~cs_s;
    assign cs_sync  = cs_s;
    assign cs_end   = cs_s & ~cs_d;

    // Bit counter and opcode shift register, cleared while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (rise_stb) begin
            shreg <= {shreg[OPW-2:0], si_s};
            if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign op_stb    = rise_stb && (bit_cnt == CW'(OPW - 1));
    assign op_code   = {shreg[OPW-2:0], si_s};
    assign exact_len = (bit_cnt == CW'(OPW));
endmodule

// File: rtl/flprot_cmd_ctrl.sv
// Command controller. Holds the write-enable latch, the lock register, the
// protection array and the erase timer. Write-type opcodes take effect only
// when chip select rises after exactly eight bits.
// Assumes strobes come from flprot_spi_front.
module flprot_cmd_ctrl
    import flprot_pkg::*;
#(
    parameter int          PROT_W       = 16,
    parameter logic [15:0] PROT_INIT    = 16'h0000,
    parameter logic [7:0]  LOCK_INIT    = 8'h01,
    parameter int          ERASE_CYCLES = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_stb,
    input  logic [7:0]        op_code,
    input  logic              cs_end,
    input  logic              exact_len,
    output logic              wel,
    output logic              busy,
    output logic [7:0]        lock_q,
    output logic [PROT_W-1:0] prot_q,
    output logic              rd_go,
    output logic              rd_is_lock
);
    localparam int TW = $clog2(ERASE_CYCLES + 1);
    localparam logic [TW-1:0] T_LAST = TW'(ERASE_CYCLES - 1);

    pend_e         pend;
    logic [TW-1:0] tmr;

    // Read start decode: status always, lock only when idle.
    always_comb begin
        rd_go      = op_stb && ((op_code == OP_RDSR) ||
                                (op_code == OP_RDLOCK && !busy));
        rd_is_lock = (op_code == OP_RDLOCK);
    end

    // Record write-type opcodes at the eighth bit; ignored while busy.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_end) begin
            pend <= PEND_NONE;
        end else if (op_stb && !busy) begin
            case (op_code)
                OP_WREN:    pend <= PEND_WREN;
                OP_ERASE:   pend <= PEND_ERASE;
                OP_LOCKSET: pend <= PEND_LOCK;
                OP_SUSPEND: pend <= PEND_NONE;
                default:    pend <= PEND_NONE;
            endcase
        end
    end

    // Execute pending commands on deselect and run the erase timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel    <= 1'b0;
            busy   <= 1'b0;
            tmr    <= '0;
            lock_q <= LOCK_INIT;
            prot_q <= PROT_W'(PROT_INIT);
        end else if (busy) begin
            if (tmr == T_LAST) begin
                busy   <= 1'b0;
                wel    <= 1'b0;
                prot_q <= '1;
                tmr    <= '0;
            end else begin
                tmr <= tmr + 1'b1;
            end
        end else if (cs_end) begin
            case (pend)
                PEND_WREN: if (exact_len) wel <= 1'b1;
                PEND_LOCK: if (exact_len) lock_q[0] <= 1'b0;
                PEND_ERASE: begin
                    if (!exact_len) begin
                        wel <= 1'b0;
                    end else if (wel) begin
                        busy <= 1'b1;
                        tmr  <= '0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/flprot_so_shift.sv
// Output shifter. After a read opcode it presents the selected byte MSB first,
// one bit per falling SCK, wrapping every eight bits. It releases SO as soon as
// chip select is seen high.
// Assumes the byte source is live and chosen by rd_lock.
module flprot_so_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_sync,
    input  logic       fall_stb,
    input  logic       rd_go,
    input  logic       rd_is_lock,
    input  logic [7:0] cur_byte,
    output logic       rd_lock,
    output logic       so_o,
    output logic       so_oe
);
    logic       active;
    logic [2:0] idx;

    // Read session state and bit-by-bit output on falling SCK.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_sync) begin
            active  <= 1'b0;
            rd_lock <= 1'b0;
            idx     <= '0;
            so_o    <= 1'b0;
            so_oe   <= 1'b0;
        end else if (rd_go) begin
            active  <= 1'b1;
            rd_lock <= rd_is_lock;
            idx     <= '0;
        end else if (fall_stb && active) begin
            so_o  <= cur_byte[3'd7 - idx];
            idx   <= idx + 1'b1;
            so_oe <= 1'b1;
        end
    end
endmodule

// File: rtl/flprot_engine.sv
// Top of the protection-bit command engine: front end, controller and output
// shifter. Assumes sck, cs_n and si are asynchronous to clk and slower than it.
module flprot_engine #(
    parameter int          PROT_W       = 16,
    parameter logic [15:0] PROT_INIT    = 16'h0000,
    parameter int          ERASE_CYCLES = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    output logic              so_o,
    output logic              so_oe,
    output logic [PROT_W-1:0] prot_bits
);
    logic       cs_sync, fall_stb, op_stb, cs_end, exact_len;
    logic [7:0] op_code;
    logic       wel, busy, rd_go, rd_is_lock, rd_lock;
    logic [7:0] lock_q, cur_byte;

    flprot_spi_front #(.OPW(8)) u_front (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .cs_sync(cs_sync), .fall_stb(fall_stb), .op_stb(op_stb),
        .op_code(op_code), .cs_end(cs_end), .exact_len(exact_len)
    );

    flprot_cmd_ctrl #(
        .PROT_W(PROT_W), .PROT_INIT(PROT_INIT), .LOCK_INIT(8'h01),
        .ERASE_CYCLES(ERASE_CYCLES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .op_stb(op_stb), .op_code(op_code),
        .cs_end(cs_end), .exact_len(exact_len), .wel(wel), .busy(busy),
        .lock_q(lock_q), .prot_q(prot_bits), .rd_go(rd_go),
        .rd_is_lock(rd_is_lock)
    );

    // Byte presented to the shifter: lock register or live status.
    assign cur_byte = rd_lock ? lock_q : {6'b0, wel, busy};

    flprot_so_shift u_so (
        .clk(clk), .rst_n(rst_n), .cs_sync(cs_sync), .fall_stb(fall_stb),
        .rd_go(rd_go), .rd_is_lock(rd_is_lock), .cur_byte(cur_byte),
        .rd_lock(rd_lock), .so_o(so_o), .so_oe(so_oe)
    );
endmodule

// File: rtl/flprot_engine_chk.sv
// Assertion checker for flprot_engine, attached by bind below.
module flprot_engine_chk #(
    parameter int PROT_W       = 16,
    parameter int ERASE_CYCLES = 2000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_sync,
    input logic              so_oe,
    input logic              busy,
    input logic              wel,
    input logic              rd_lock,
    input logic [PROT_W-1:0] prot_bits
);
    localparam int BW = $clog2(ERASE_CYCLES + 2) + 1;
    logic [BW-1:0] busy_len;

    // Counts consecutive busy cycles to measure the erase window.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_len <= '0;
        else                 busy_len <= busy_len + 1'b1;
    end

    // R11
    so_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_sync |=> !so_oe);
    // R6
    erase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == BW'(ERASE_CYCLES)));
    // R6
    prot_end_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot_bits) |-> ($past(busy) && !busy));
    // R6
    wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);
    // R7
    erase_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel));
    // R4
    lock_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && rd_lock) |-> !busy);
endmodule

bind flprot_engine flprot_engine_chk #(
    .PROT_W(PROT_W), .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_sync(cs_sync), .so_oe(so_oe),
    .busy(busy), .wel(wel), .rd_lock(rd_lock), .prot_bits(prot_bits)
);

// File: tb/tb_flprot_engine.sv
module tb_flprot_engine;
    localparam int          PW    = 16;
    localparam logic [15:0] PINIT = 16'h0000;
    localparam int          ECYC  = 2000;
    localparam int          HALF  = 8;

    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic so_o, so_oe;
    logic [PW-1:0] prot_bits;
    int total = 0, bad = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    flprot_engine #(.PROT_W(PW), .PROT_INIT(PINIT), .ERASE_CYCLES(ECYC)) dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .so_o(so_o), .so_oe(so_oe), .prot_bits(prot_bits)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [1:0]  nread;
        logic [15:0] exp;
        logic        oe;
    } vec_t;

    // R3 status stream, R2 write enable, R4 lock stream, R11 unknown opcode.
    localparam vec_t VEC [6] = '{
        '{op: 8'h05, nread: 2'd1, exp: 16'h0000, oe: 1'b1},
        '{op: 8'h06, nread: 2'd0, exp: 16'h0000, oe: 1'b0},
        '{op: 8'h05, nread: 2'd1, exp: 16'h0002, oe: 1'b1},
        '{op: 8'hA7, nread: 2'd1, exp: 16'h0001, oe: 1'b1},
        '{op: 8'h05, nread: 2'd2, exp: 16'h0202, oe: 1'b1},
        '{op: 8'h9F, nread: 2'd1, exp: 16'h0000, oe: 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One selection: nbits opcode bits (extra bits are 0), then nread bytes.
    task automatic spi_cmd(input logic [7:0] op, input int nbits, input int nread,
                           output logic [15:0] rd, output logic oe_seen);
        rd = '0;
        oe_seen = 1'b0;
        @(negedge clk);
        cs_n = 1'b0;
        wclk(HALF);
        for (int i = 0; i < nbits; i++) begin
            si = (i < 8) ? op[7-i] : 1'b0;
            oe_seen |= so_oe;
            wclk(HALF);
            sck = 1'b1;
            wclk(HALF);
            sck = 1'b0;
        end
        for (int j = 0; j < nread * 8; j++) begin
            wclk(HALF);
            rd = {rd[14:0], so_o};
            oe_seen |= so_oe;
            sck = 1'b1;
            wclk(HALF);
            sck = 1'b0;
        end
        wclk(HALF);
        oe_seen |= so_oe;
        cs_n = 1'b1;
        wclk(2 * HALF);
    endtask

    task automatic read_status(output logic [7:0] v);
        logic [15:0] r;
        logic o;
        spi_cmd(8'h05, 8, 1, r, o);
        v = r[7:0];
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] rd;
        logic oe;
        logic [7:0] st;
        wclk(5);
        rst_n = 1'b1;
        wclk(3);
        // R1 reset state at the pins
        check("R1 so_oe", {31'b0, so_oe}, 32'd0);
        check("R1 prot", {16'b0, prot_bits}, {16'b0, PINIT});

        foreach (VEC[k]) begin
            spi_cmd(VEC[k].op, 8, int'(VEC[k].nread), rd, oe);
            if (VEC[k].nread != 0 && VEC[k].oe)
                check($sformatf("R3/R4 vec%0d data", k), {16'b0, rd},
                      {16'b0, VEC[k].exp});
            check($sformatf("R11 vec%0d oe", k), {31'b0, oe}, {31'b0, VEC[k].oe});
        end

        // R8: erase with nine bits while WEL set
        spi_cmd(8'hE4, 9, 0, rd, oe);
        read_status(st);
        check("R8 status", {24'b0, st}, 32'h00);
        check("R8 prot", {16'b0, prot_bits}, {16'b0, PINIT});

        // R7: erase without WEL
        spi_cmd(8'hE4, 8, 0, rd, oe);
        read_status(st);
        check("R7 status", {24'b0, st}, 32'h00);
        check("R7 prot", {16'b0, prot_bits}, {16'b0, PINIT});

        // R6: valid erase, with traffic during busy
        spi_cmd(8'h06, 8, 0, rd, oe);
        spi_cmd(8'hE4, 8, 0, rd, oe);
        read_status(st);
        check("R6 busy status", {24'b0, st}, 32'h03);
        spi_cmd(8'hA7, 8, 1, rd, oe);
        check("R4 lock refused while busy", {31'b0, oe}, 32'd0);
        spi_cmd(8'h75, 8, 0, rd, oe);
        spi_cmd(8'hA6, 8, 0, rd, oe);
        read_status(st);
        check("R9 suspend ignored", {24'b0, st}, 32'h03);
        check("R6 prot not yet", {16'b0, prot_bits}, {16'b0, PINIT});
        wclk(1400);
        read_status(st);
        check("R6 done status", {24'b0, st}, 32'h00);
        check("R6 prot all ones", {16'b0, prot_bits}, 32'h0000FFFF);
        spi_cmd(8'hA7, 8, 1, rd, oe);
        check("R10 lock kept", {16'b0, rd}, 32'h01);

        // R5: lock set, then read back twice to cover repetition
        spi_cmd(8'hA6, 8, 0, rd, oe);
        spi_cmd(8'hA7, 8, 2, rd, oe);
        check("R5 lock cleared", {16'b0, rd}, 32'h0000);
        check("R11 lock read drives", {31'b0, oe}, 32'd1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule